// File: doc/BRIEF.md
# Scroll Plane Scanline Renderer

This block draws one horizontal line of a tiled background plane. A start pulse supplies the line number, the raw vertical scroll word, the plane-size codes, the transparent colour index and the two register bytes that place the plane's name table and the horizontal scroll table in video memory. The block then reads the horizontal scroll word and walks across the plane one cell at a time. For each cell it reads the name-table entry and the two halves of the addressed tile row. It shifts the row out as eight 4-bit colour indices.

Each index that is not transparent and lands inside the visible width is looked up in a 16-entry colour memory. The result is emitted as a 24-bit RGB pixel write with its screen x position. A single-cycle `done` pulse follows the last possible write. Each cell takes eight clocks. The fetch for the next cell overlaps the output of the current cell, so video memory is read at most three times in any eight-clock slot.

Top module: `plane_line_renderer`

## Requirements
- R1: The width and height size codes 0, 1 and 3 select planes of 32, 64 and 128 cells. Each cell is 8x8 pixels. A line takes 8 clocks per cell of plane width, plus fixed overhead: `done` is high after the (8*cells+13)-th rising edge, counting the edge that samples `start` as the first. The line issues exactly 1+3*cells video memory reads.
- R2: When either size code is 2, the line is skipped. There are no memory reads and no pixel writes, and `done` is high after the edge that samples `start`.
- R3: Of the vertical scroll word and the horizontal scroll word (read from video memory), only bits 9:0 take effect.
- R4: The source row is (line + vscroll) modulo the plane height in pixels. Its bits above 2 give the cell row cy, and its bits 2:0 give the row inside the tile.
- R5: The name-table entry of cell (cx, cy) is the 16-bit word at byte address base + 2*(cy*widthCells + cx), modulo 2^16.
- R6: The low 11 bits of a name entry select a tile. Its row is the 32-bit word formed by the 16-bit words at (tile*32 + row*4) and that address + 2, modulo 2^16, with the first word as the upper half. The pixel at column 0 comes from bits 31:28, and each following column comes from the next lower nibble.
- R7: A pixel's screen x is (cx*8 + column + hscroll) modulo the plane width in pixels. A pixel with x of 320 or more is not written.
- R8: A pixel whose 4-bit index equals `bg_index` (latched at start) is not written.
- R9: A written pixel carries RGB = {c[3:1],00000, c[7:5],00000, c[11:9],00000}, where c is the colour memory word at that index (red in bits 23:16).
- R10: With `plane_sel`=0 the name table is at plane_reg[5:3]<<13. With `plane_sel`=1 it is at plane_reg[2:0]<<13. The horizontal scroll word is at (table_reg[5:0]<<10) + 2*plane_sel.
- R11: Pixel writes of a line come in increasing cell order and column order. `done` lasts exactly one cycle, and no pixel write appears while the block is idle.
- R12: After reset `px_valid`, `done` and `vram_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a line (ignored while busy) |
| line_idx | input | 10 | Screen line number |
| vscroll_word | input | 16 | Raw vertical scroll word for this plane |
| plane_reg | input | 8 | Name-table placement register byte |
| plane_sel | input | 1 | 0: first plane decoding, 1: second plane decoding |
| table_reg | input | 8 | Horizontal scroll table placement register byte |
| size_w | input | 2 | Plane width code |
| size_h | input | 2 | Plane height code |
| bg_index | input | 4 | Transparent colour index |
| vram_rd | output | 1 | Video memory read strobe |
| vram_addr | output | 16 | Video memory byte address (even) |
| vram_rdata | input | 16 | Read data, valid the cycle after the strobe |
| cram_addr | output | 4 | Colour memory index |
| cram_rdata | input | 16 | Colour word, valid the cycle after the index |
| px_valid | output | 1 | Pixel write strobe |
| px_x | output | 9 | Screen x of the pixel write |
| px_rgb | output | 24 | Pixel colour, red in the top byte |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
Lines are rendered with every allowed width and height code, with scroll values that do and do not wrap around the plane, and with garbage in the upper scroll bits. Matching pixel streams separate correct wrapping from plain addition and a 10-bit mask from a full-word scroll. Both plane decodings and two different transparent indices are used over pseudo-random tile memory, which exposes nibble-order, address and colour-field mistakes. Runs with the forbidden size code on each axis confirm that nothing is read or written. The latency and read counts then tell the three legal widths apart.

// File: rtl/plane_render_pkg.sv
// Shared constants, state encoding and helper functions for the scroll
// plane line renderer. Assumes 16-bit video memory words, byte addresses.
package plane_render_pkg;
    localparam int ADDR_W  = 16;
    localparam int WORD_W  = 16;
    localparam int ROW_W   = 32;
    localparam int NIB_W   = 4;
    localparam int TILE_W  = 11;
    localparam int CELL_PX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HSREQ,
        ST_HSCAP,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } fetch_state_t;

    // Size code 2 is forbidden; others are legal.
    function automatic logic size_ok(input logic [1:0] code);
        return code != 2'd2;
    endfunction

    // log2(cells/32) for a legal size code.
    function automatic logic [1:0] size_log(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // Colour memory word to 24-bit RGB, each 3-bit field shifted up by 5.
    function automatic logic [23:0] word_to_rgb(input logic [WORD_W-1:0] w);
        return {w[3:1], 5'b0, w[7:5], 5'b0, w[11:9], 5'b0};
    endfunction
endpackage

// File: rtl/plane_base_dec.sv
// Decodes the register bytes that place the name table and the horizontal
// scroll table into byte addresses. Purely combinational.
module plane_base_dec
    import plane_render_pkg::*;
(
    input  logic [7:0]        plane_reg,
    input  logic              plane_sel,
    input  logic [7:0]        table_reg,
    output logic [ADDR_W-1:0] plane_base,
    output logic [ADDR_W-1:0] hs_addr
);
    // Name-table base: field choice depends on which plane is rendered.
    always_comb begin
        if (plane_sel)
            plane_base = {plane_reg[2:0], 13'b0};
        else
            plane_base = {plane_reg[5:3], 13'b0};
    end

    // Scroll table base plus one word per plane.
    always_comb begin
        hs_addr = {table_reg[5:0], 10'b0} + {{(ADDR_W-2){1'b0}}, plane_sel, 1'b0};
    end
endmodule

// File: rtl/plane_fetch.sv
// Sequencer and video memory fetcher. On start it latches the line setup,
// reads the horizontal scroll word, then runs one 8-clock slot per cell:
// name read (phase 0), tile upper half (1), tile lower half (2), capture
// (3), hand-off of the finished row to the shifter (7). One extra slot
// drains the last row. Memory read data is valid the cycle after a strobe.
module plane_fetch
    import plane_render_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int SCROLL_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LINE_W-1:0]   line_idx,
    input  logic [WORD_W-1:0]   vscroll_word,
    input  logic [ADDR_W-1:0]   plane_base,
    input  logic [ADDR_W-1:0]   hs_addr,
    input  logic [1:0]          size_w,
    input  logic [1:0]          size_h,
    input  logic [WORD_W-1:0]   vram_rdata,
    output logic                vram_rd,
    output logic [ADDR_W-1:0]   vram_addr,
    output logic                row_load,
    output logic [ROW_W-1:0]    row_word,
    output logic [6:0]          row_cx,
    output logic [SCROLL_W-1:0] hs_val,
    output logic [1:0]          wlog,
    output logic                busy,
    output logic                done
);
    localparam int SUM_W = ((LINE_W > SCROLL_W) ? LINE_W : SCROLL_W) + 1;

    fetch_state_t       state;
    logic [2:0]         ph;
    logic [7:0]         slot;
    logic               drain_cnt;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  hsa_q;
    logic [6:0]         cy_q;
    logic [2:0]         trow_q;
    logic [1:0]         wlog_q;
    logic [TILE_W-1:0]  tile_q;
    logic [ROW_W-1:0]   pend_q;
    logic [SCROLL_W-1:0] hs_q;

    logic [SUM_W-1:0]   src_sum;
    logic [SUM_W-1:0]   hmask;
    logic [SUM_W-1:0]   src_row;
    logic [7:0]         wcells;
    logic               fetching;
    logic               bad_size;
    logic [ADDR_W-1:0]  name_off;

    // Source row of the plane for this line, wrapped to the plane height.
    always_comb begin
        src_sum = SUM_W'(line_idx) + SUM_W'(vscroll_word[SCROLL_W-1:0]);
        hmask   = (SUM_W'(256) << size_log(size_h)) - SUM_W'(1);
        src_row = src_sum & hmask;
        bad_size = !(size_ok(size_w) && size_ok(size_h));
    end

    // Slot bookkeeping and name-table offset of the cell being fetched.
    always_comb begin
        wcells   = 8'd32 << wlog_q;
        fetching = (state == ST_RUN) && (slot < wcells);
        name_off = (ADDR_W'(cy_q) << (5 + wlog_q)) + ADDR_W'(slot);
    end

    // Read strobe and address for the current state and phase.
    always_comb begin
        vram_rd   = 1'b0;
        vram_addr = '0;
        if (state == ST_HSREQ) begin
            vram_rd   = 1'b1;
            vram_addr = hsa_q;
        end else if (fetching) begin
            case (ph)
                3'd0: begin
                    vram_rd   = 1'b1;
                    vram_addr = base_q + (name_off << 1);
                end
                3'd1: begin
                    vram_rd   = 1'b1;
                    vram_addr = {vram_rdata[TILE_W-1:0], trow_q, 2'b00};
                end
                3'd2: begin
                    vram_rd   = 1'b1;
                    vram_addr = {tile_q, trow_q, 2'b10};
                end
                default: ;
            endcase
        end
    end

    // Main sequencer: setup latch, scroll read, cell slots, drain, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ph        <= '0;
            slot      <= '0;
            drain_cnt <= 1'b0;
            base_q    <= '0;
            hsa_q     <= '0;
            cy_q      <= '0;
            trow_q    <= '0;
            wlog_q    <= '0;
            tile_q    <= '0;
            pend_q    <= '0;
            hs_q      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= plane_base;
                        hsa_q  <= hs_addr;
                        cy_q   <= src_row[9:3];
                        trow_q <= src_row[2:0];
                        wlog_q <= size_log(size_w);
                        state  <= bad_size ? ST_DONE : ST_HSREQ;
                    end
                end
                ST_HSREQ: state <= ST_HSCAP;
                ST_HSCAP: begin
                    hs_q  <= vram_rdata[SCROLL_W-1:0];
                    ph    <= '0;
                    slot  <= '0;
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    if (fetching) begin
                        if (ph == 3'd1) tile_q <= vram_rdata[TILE_W-1:0];
                        if (ph == 3'd2) pend_q[ROW_W-1:WORD_W] <= vram_rdata;
                        if (ph == 3'd3) pend_q[WORD_W-1:0] <= vram_rdata;
                    end
                    ph <= ph + 3'd1;
                    if (ph == 3'd7) begin
                        slot <= slot + 8'd1;
                        if (slot == wcells) begin
                            state     <= ST_DRAIN;
                            drain_cnt <= 1'b0;
                        end
                    end
                end
                ST_DRAIN: begin
                    drain_cnt <= 1'b1;
                    if (drain_cnt) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign row_load = fetching && (ph == 3'd7);
    assign row_word = pend_q;
    assign row_cx   = slot[6:0];
    assign hs_val   = hs_q;
    assign wlog     = wlog_q;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_BAD_SIZE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && bad_size) |=> (!vram_rd && done)); // R2
    AST_ROW_LOAD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        row_load |=> !row_load); // R11
endmodule

// File: rtl/plane_pixel_out.sv
// Shifts a loaded 32-bit tile row out as eight 4-bit indices, one per clock,
// computes the wrapped screen x, drops transparent and off-screen pixels,
// looks the index up in colour memory (one-cycle read) and registers the
// RGB pixel write. Output appears two clocks after the shifted nibble.
module plane_pixel_out
    import plane_render_pkg::*;
#(
    parameter int VIS_W    = 320,
    parameter int SCROLL_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                row_load,
    input  logic [ROW_W-1:0]    row_word,
    input  logic [6:0]          row_cx,
    input  logic [SCROLL_W-1:0] hs_val,
    input  logic [1:0]          wlog,
    input  logic [NIB_W-1:0]    bg_index,
    input  logic [WORD_W-1:0]   cram_rdata,
    output logic [NIB_W-1:0]    cram_addr,
    output logic                px_valid,
    output logic [$clog2(VIS_W)-1:0] px_x,
    output logic [23:0]         px_rgb
);
    localparam int XW  = $clog2(VIS_W);
    localparam int XSW = SCROLL_W + 1;

    logic [ROW_W-1:0] cur_q;
    logic [6:0]       cx_q;
    logic [2:0]       col_q;
    logic             active_q;
    logic [NIB_W-1:0] nib;
    logic [XSW-1:0]   x_sum;
    logic [XSW-1:0]   wmask;
    logic [XSW-1:0]   x_wrap;
    logic             wr_now;
    logic             s1_valid;
    logic [XW-1:0]    s1_x;

    // Row shifter: a load restarts it, otherwise it steps one column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cx_q     <= '0;
            col_q    <= '0;
            active_q <= 1'b0;
        end else if (row_load) begin
            cur_q    <= row_word;
            cx_q     <= row_cx;
            col_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            cur_q <= cur_q << NIB_W;
            col_q <= col_q + 3'd1;
            if (col_q == 3'd7) active_q <= 1'b0;
        end
    end

    // Screen position, visibility and transparency of the current nibble.
    always_comb begin
        nib    = cur_q[ROW_W-1 -: NIB_W];
        x_sum  = XSW'({cx_q, 3'b000}) + XSW'(col_q) + XSW'(hs_val);
        wmask  = (XSW'(256) << wlog) - XSW'(1);
        x_wrap = x_sum & wmask;
        wr_now = active_q && (x_wrap < XSW'(VIS_W)) && (nib != bg_index);
    end

    assign cram_addr = nib;

    // Stage 1: hold write intent and x while colour memory is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x     <= '0;
        end else begin
            s1_valid <= wr_now;
            s1_x     <= x_wrap[XW-1:0];
        end
    end

    // Stage 2: register the converted pixel write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_valid <= 1'b0;
            px_x     <= '0;
            px_rgb   <= '0;
        end else begin
            px_valid <= s1_valid;
            px_x     <= s1_x;
            px_rgb   <= word_to_rgb(cram_rdata);
        end
    end

    AST_X_INSIDE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (px_x < XW'(VIS_W))); // R7
    AST_TRANSPARENT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> ($past(cram_addr, 2) != $past(bg_index, 2))); // R8
endmodule

// File: rtl/plane_line_renderer.sv
// Top of the scroll plane scanline renderer. Decodes the table placement
// registers, latches the transparent index at start, and connects the
// fetch sequencer to the pixel shifter/colour stage. Start is ignored
// while a line is in progress.
module plane_line_renderer
    import plane_render_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int SCROLL_W = 10,
    parameter int VIS_W    = 320
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [LINE_W-1:0]        line_idx,
    input  logic [15:0]              vscroll_word,
    input  logic [7:0]               plane_reg,
    input  logic                     plane_sel,
    input  logic [7:0]               table_reg,
    input  logic [1:0]               size_w,
    input  logic [1:0]               size_h,
    input  logic [3:0]               bg_index,
    output logic                     vram_rd,
    output logic [15:0]              vram_addr,
    input  logic [15:0]              vram_rdata,
    output logic [3:0]               cram_addr,
    input  logic [15:0]              cram_rdata,
    output logic                     px_valid,
    output logic [$clog2(VIS_W)-1:0] px_x,
    output logic [23:0]              px_rgb,
    output logic                     done
);
    logic [ADDR_W-1:0]   plane_base;
    logic [ADDR_W-1:0]   hs_addr;
    logic                row_load;
    logic [ROW_W-1:0]    row_word;
    logic [6:0]          row_cx;
    logic [SCROLL_W-1:0] hs_val;
    logic [1:0]          wlog;
    logic                busy;
    logic [NIB_W-1:0]    bg_q;

    plane_base_dec u_dec (
        .plane_reg  (plane_reg),
        .plane_sel  (plane_sel),
        .table_reg  (table_reg),
        .plane_base (plane_base),
        .hs_addr    (hs_addr)
    );

    // Latch the transparent index when a line is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bg_q <= '0;
        else if (start && !busy)
            bg_q <= bg_index;
    end

    plane_fetch #(
        .LINE_W   (LINE_W),
        .SCROLL_W (SCROLL_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .line_idx     (line_idx),
        .vscroll_word (vscroll_word),
        .plane_base   (plane_base),
        .hs_addr      (hs_addr),
        .size_w       (size_w),
        .size_h       (size_h),
        .vram_rdata   (vram_rdata),
        .vram_rd      (vram_rd),
        .vram_addr    (vram_addr),
        .row_load     (row_load),
        .row_word     (row_word),
        .row_cx       (row_cx),
        .hs_val       (hs_val),
        .wlog         (wlog),
        .busy         (busy),
        .done         (done)
    );

    plane_pixel_out #(
        .VIS_W    (VIS_W),
        .SCROLL_W (SCROLL_W)
    ) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_load   (row_load),
        .row_word   (row_word),
        .row_cx     (row_cx),
        .hs_val     (hs_val),
        .wlog       (wlog),
        .bg_index   (bg_q),
        .cram_rdata (cram_rdata),
        .cram_addr  (cram_addr),
        .px_valid   (px_valid),
        .px_x       (px_x),
        .px_rgb     (px_rgb)
    );

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !px_valid); // R11
endmodule

// File: tb/plane_line_renderer_test.sv
// Scoreboard bench: the driver computes the expected pixel writes of a line
// from the requirements and queues them; the monitor compares each write.
module plane_line_renderer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  line_idx = '0;
    logic [15:0] vscroll_word = '0;
    logic [7:0]  plane_reg = '0;
    logic        plane_sel = 1'b0;
    logic [7:0]  table_reg = '0;
    logic [1:0]  size_w = '0;
    logic [1:0]  size_h = '0;
    logic [3:0]  bg_index = '0;
    logic        vram_rd;
    logic [15:0] vram_addr;
    logic [15:0] vram_rdata = '0;
    logic [3:0]  cram_addr;
    logic [15:0] cram_rdata = '0;
    logic        px_valid;
    logic [8:0]  px_x;
    logic [23:0] px_rgb;
    logic        done;

    int checks = 0;
    int fails = 0;
    int rd_count = 0;
    logic [32:0] expq [$];
    logic [15:0] ovr [int];
    logic [15:0] cmem [16];

    always #10 clk = ~clk;

    plane_line_renderer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .line_idx(line_idx),
        .vscroll_word(vscroll_word), .plane_reg(plane_reg),
        .plane_sel(plane_sel), .table_reg(table_reg), .size_w(size_w),
        .size_h(size_h), .bg_index(bg_index), .vram_rd(vram_rd),
        .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .cram_addr(cram_addr), .cram_rdata(cram_rdata),
        .px_valid(px_valid), .px_x(px_x), .px_rgb(px_rgb), .done(done)
    );

    function automatic logic [15:0] vrd(input int addr);
        int key;
        logic [31:0] t;
        key = (addr & 16'hFFFF) >> 1;
        if (ovr.exists(key)) return ovr[key];
        t = key * 32'd40503 + 32'd12345;
        return t[15:0] ^ t[26:11];
    endfunction

    function automatic logic [23:0] to_rgb(input logic [15:0] c);
        return {c[3:1], 5'b0, c[7:5], 5'b0, c[11:9], 5'b0};
    endfunction

    // Memory models: one-cycle read latency.
    always @(posedge clk) begin
        if (vram_rd) vram_rdata <= vrd(int'(vram_addr));
        cram_rdata <= cmem[cram_addr];
    end

    always @(negedge clk) if (rst_n && vram_rd) rd_count++;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Monitor: compare each pixel write against the queue head.
    always @(negedge clk) begin
        if (rst_n && px_valid) begin
            if (expq.size() == 0) begin
                check(0, "R7 R8 unexpected pixel write", int'({px_x, px_rgb}), 0);
            end else begin
                logic [32:0] e;
                e = expq.pop_front();
                check({px_x, px_rgb} == e, "R4 R5 R6 R7 R8 R9 R10 R11 pixel",
                      int'({px_x, px_rgb}), int'(e));
            end
        end
    end

    // Driver: build expected writes, run the line, check latency and reads.
    task automatic run_line(input logic [9:0] ln, input logic [15:0] vsw,
                            input logic [15:0] hsw, input logic [7:0] preg,
                            input logic psel, input logic [7:0] treg,
                            input logic [1:0] wc, input logic [1:0] hc,
                            input logic [3:0] bg);
        int wcells, hcells, base, hsa, vs, hs, src, cy, trow, n;
        bit bad;
        bad = (wc == 2) || (hc == 2);
        wcells = (wc == 3) ? 128 : (32 << wc);
        hcells = (hc == 3) ? 128 : (32 << hc);
        base = psel ? ((preg & 7) << 13) : (((preg >> 3) & 7) << 13);    // R10
        hsa  = ((treg & 8'h3F) << 10) + (psel ? 2 : 0);                  // R10
        ovr[hsa >> 1] = hsw;
        vs = vsw & 10'h3FF;                                              // R3
        hs = hsw & 10'h3FF;                                              // R3
        src = (ln + vs) % (hcells * 8);                                  // R4
        cy = src / 8;
        trow = src % 8;
        if (!bad) begin
            for (int cx = 0; cx < wcells; cx++) begin
                int tile, ta, x;
                logic [31:0] row;
                tile = vrd(base + (cy * wcells + cx) * 2) & 16'h07FF;    // R5
                ta = tile * 32 + trow * 4;
                row = {vrd(ta), vrd(ta + 2)};                            // R6
                for (int p = 0; p < 8; p++) begin
                    logic [3:0] nb;
                    nb = row[31 - 4 * p -: 4];
                    x = (cx * 8 + p + hs) % (wcells * 8);                // R7
                    if (x < 320 && nb != bg)                             // R8
                        expq.push_back({9'(x), to_rgb(cmem[nb])});       // R9
                end
            end
        end
        rd_count = 0;
        line_idx = ln; vscroll_word = vsw; plane_reg = preg; plane_sel = psel;
        table_reg = treg; size_w = wc; size_h = hc; bg_index = bg;
        start = 1'b1;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            if (n > 5000) break;
        end
        if (bad) begin
            check(n == 1, "R2 done latency", n, 1);
            check(rd_count == 0, "R2 read count", rd_count, 0);
        end else begin
            check(n == 8 * wcells + 13, "R1 line latency", n, 8 * wcells + 13);
            check(rd_count == 1 + 3 * wcells, "R1 read count", rd_count, 1 + 3 * wcells);
        end
        check(expq.size() == 0, "R11 missing pixel writes", expq.size(), 0);
        expq.delete();
        @(negedge clk);
        check(!done, "R11 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) cmem[i] = 16'((i * 16'h1357) ^ 16'hA5A5);
        repeat (3) @(negedge clk);
        // R12: outputs low during and after reset
        check(!px_valid && !done && !vram_rd, "R12 reset outputs", int'({px_valid, done, vram_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!px_valid && !done && !vram_rd, "R12 idle after reset", int'({px_valid, done, vram_rd}), 0);
        // first plane decoding, 32x32, small scroll with junk upper bits
        run_line(10'd5, 16'hFC03, 16'hFC10, 8'h08, 1'b0, 8'h0D, 2'd0, 2'd0, 4'h0);
        // second plane decoding, 64 wide, 128 high, both axes wrap
        run_line(10'd200, 16'h0350, 16'h03FF, 8'h02, 1'b1, 8'h0D, 2'd1, 2'd3, 4'h5);
        // 128 wide, 32 high, vertical wrap with all-ones scroll word
        run_line(10'd250, 16'hFFFF, 16'h02BC, 8'h38, 1'b0, 8'h3F, 2'd3, 2'd0, 4'hF);
        // 32 wide, 64 high, no horizontal scroll
        run_line(10'd63, 16'h0000, 16'h0000, 8'h15, 1'b1, 8'h21, 2'd0, 2'd1, 4'h9);
        // forbidden size code on each axis (R2)
        run_line(10'd7, 16'h0001, 16'h0002, 8'h08, 1'b0, 8'h0D, 2'd2, 2'd0, 4'h0);
        run_line(10'd7, 16'h0001, 16'h0002, 8'h08, 1'b0, 8'h0D, 2'd1, 2'd2, 4'h0);
        // a legal line after the skipped ones
        run_line(10'd100, 16'h0123, 16'hF0F7, 8'h28, 1'b0, 8'h02, 2'd1, 2'd1, 4'h3);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule